// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Syndrome Checker

This block decides whether a hard-decision word satisfies every parity check of a quasi-cyclic low-density parity-check code. The check matrix is built from a compile-time grid of block entries. Each entry is either an empty Z×Z sub-block or a Z×Z identity matrix whose columns are rotated right by a small shift value. A dense matrix is never stored. The check bits are produced by rotating slices of the word and XOR-ing them together.

A client places the whole word on `cw_in` and pulses `start`. The block then scans one block-row per clock and adds the number of failing checks in that block-row to a saturating tally. When the scan ends it raises `done` for one cycle and publishes a pass flag and the tally. The pass flag is high only when the syndrome is the all-zero vector. Both results hold until the next completed scan.

The controller has three states:
- `S_IDLE` waits for work.
- `S_SCAN` processes block-rows.
- `S_REPORT` publishes the result.

Its transitions are:
- idle→scan on an accepted start.
- scan→scan while block-rows remain.
- scan→report after the last block-row.
- report→idle unconditionally.

Top module: `qc_syndrome_check`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `valid` and `unsat_cnt` are all zero until the first scan completes.
- R2: Word bit k is `cw_in[k]`, and block-column j covers bits j·Z to j·Z+Z−1. For block-row i with shift s, check bit r (0 ≤ r < Z) includes word bit j·Z + ((r+s) mod Z).
- R3: A shift field of all ones (63 for a 6-bit field) marks an empty sub-block that contributes nothing. A shift of 0 is the plain identity and does contribute.
- R4: `valid` is 1 exactly when all MB·Z syndrome bits are zero, and `unsat_cnt` is the number of syndrome bits equal to one.
- R5: `done` is high for exactly one cycle. It rises on the (MB+1)-th rising edge after the edge that accepted `start`.
- R6: `unsat_cnt` saturates at 2^CNT_W−1 instead of wrapping.
- R7: A `start` raised while a scan or report is in progress is ignored. A later `start` after the report begins a new scan with the tally cleared.
- R8: `valid` and `unsat_cnt` change only in the cycle where `done` is high, and otherwise hold their last values.
- R9: The word is captured on the accepting edge. Later changes on `cw_in` do not affect that scan's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check of the word on `cw_in` (honoured only when idle) |
| cw_in | input | NB·Z | Hard-decision word, bit k is codeword position k |
| done | output | 1 | One-cycle pulse when a result is published |
| valid | output | 1 | Word satisfies all checks |
| unsat_cnt | output | CNT_W | Saturating count of failing checks |

## Verification
The assertions assume that every shift in the parameter table is either below Z or equal to the all-ones marker. They also assume that `start` is a synchronous level sampled on rising edges. Under those assumptions they require `done` to arrive after a fixed number of edges and the published outputs to stay frozen between pulses. The bench uses one legal table with at least one of each entry kind in it: an empty marker, a zero shift and a maximal shift. It drives `start` and `cw_in` only at falling edges. It deliberately disturbs `cw_in` and re-raises `start` in the middle of scans to probe R7 and R9.

// File: rtl/qc_ldpc_pkg.sv
package qc_ldpc_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SCAN   = 2'd1,
        S_REPORT = 2'd2
    } scan_state_t;

endpackage

// File: rtl/qc_row_syndrome.sv
module qc_row_syndrome #(
    parameter int Z  = 8,
    parameter int MB = 3,
    parameter int NB = 6,
    parameter int SW = 6,
    parameter logic [MB*NB*SW-1:0] SHIFTS = '0,
    parameter int RW = 2
) (
    input  logic [NB*Z-1:0] cw,
    input  logic [RW-1:0]   row_sel,
    output logic [Z-1:0]    syn
);
    localparam logic [SW-1:0] EMPTY_MARK = {SW{1'b1}};

    logic [Z-1:0] part [NB];

    for (genvar j = 0; j < NB; j++) begin : g_col
        logic [SW-1:0]  sh;
        logic [2*Z-1:0] dbl;
        assign sh  = SHIFTS[(int'(row_sel) * NB + j) * SW +: SW];
        // rotating the doubled slice right by sh puts bit (r+sh) mod Z at r
        assign dbl = {cw[j*Z +: Z], cw[j*Z +: Z]} >> sh;
        assign part[j] = (sh == EMPTY_MARK) ? '0 : dbl[Z-1:0];
    end

    always_comb begin
        syn = '0;
        for (int j = 0; j < NB; j++) begin
            syn = syn ^ part[j];
        end
    end
endmodule

// File: rtl/qc_sat_accum.sv
module qc_sat_accum #(
    parameter int Z     = 8,
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] acc_in,
    input  logic [Z-1:0]     bits,
    output logic [CNT_W-1:0] acc_out
);
    localparam int PW = $clog2(Z + 1);
    localparam int AW = CNT_W + PW + 1;
    localparam logic [CNT_W-1:0] CAP = {CNT_W{1'b1}};

    logic [PW-1:0] ones;
    logic [AW-1:0] sum;

    always_comb begin
        ones = '0;
        for (int b = 0; b < Z; b++) begin
            ones = ones + PW'(bits[b]);
        end
        sum = AW'(acc_in) + AW'(ones);
        if (sum > AW'(CAP)) acc_out = CAP;
        else                acc_out = sum[CNT_W-1:0];
    end
endmodule

// File: rtl/qc_syndrome_check.sv
module qc_syndrome_check
    import qc_ldpc_pkg::*;
#(
    parameter int Z  = 8,
    parameter int MB = 3,
    parameter int NB = 6,
    parameter int SW = 6,
    parameter logic [MB*NB*SW-1:0] SHIFTS = {
        6'd0,  6'd0,  6'd63, 6'd1,  6'd63, 6'd6,
        6'd4,  6'd63, 6'd0,  6'd7,  6'd2,  6'd63,
        6'd63, 6'd1,  6'd5,  6'd63, 6'd3,  6'd0 },
    parameter int CNT_W = $clog2(MB * Z + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NB*Z-1:0]      cw_in,
    output logic                 done,
    output logic                 valid,
    output logic [CNT_W-1:0]     unsat_cnt
);
    localparam int N  = NB * Z;
    localparam int RW = (MB > 1) ? $clog2(MB) : 1;
    localparam logic [RW-1:0] LAST_ROW = RW'(MB - 1);

    scan_state_t      state_q, state_d;
    logic [RW-1:0]    row_q;
    logic [N-1:0]     cw_q;
    logic [CNT_W-1:0] acc_q, acc_nxt;
    logic [Z-1:0]     syn;
    logic             accept;
    logic             busy;

    assign busy   = (state_q != S_IDLE);
    assign accept = start && (state_q == S_IDLE);

    qc_row_syndrome #(
        .Z(Z), .MB(MB), .NB(NB), .SW(SW), .SHIFTS(SHIFTS), .RW(RW)
    ) u_row (
        .cw      (cw_q),
        .row_sel (row_q),
        .syn     (syn)
    );

    qc_sat_accum #(.Z(Z), .CNT_W(CNT_W)) u_acc (
        .acc_in  (acc_q),
        .bits    (syn),
        .acc_out (acc_nxt)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_SCAN;
            S_SCAN:   if (row_q == LAST_ROW) state_d = S_REPORT;
            S_REPORT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // scan datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cw_q  <= '0;
            row_q <= '0;
            acc_q <= '0;
        end else if (accept) begin
            cw_q  <= cw_in;
            row_q <= '0;
            acc_q <= '0;
        end else if (state_q == S_SCAN) begin
            acc_q <= acc_nxt;
            row_q <= row_q + RW'(1);
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            valid     <= 1'b0;
            unsat_cnt <= '0;
        end else begin
            done <= (state_q == S_REPORT);
            if (state_q == S_REPORT) begin
                valid     <= (acc_q == '0);
                unsat_cnt <= acc_q;
            end
        end
    end
endmodule

// File: rtl/qc_syndrome_check_sva.sv
module qc_syndrome_check_sva #(
    parameter int MB    = 3,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             valid,
    input logic [CNT_W-1:0] unsat_cnt
);
    localparam int TW = $clog2(MB + 3);

    logic          trk_on;
    logic [TW-1:0] trk_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_on  <= 1'b0;
            trk_cnt <= '0;
        end else if (start && !busy) begin
            trk_on  <= 1'b1;
            trk_cnt <= '0;
        end else if (done) begin
            trk_on  <= 1'b0;
        end else if (trk_on) begin
            trk_cnt <= trk_cnt + TW'(1);
        end
    end

    a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (trk_on && trk_cnt == TW'(MB + 1)));

    a_r4_valid_iff_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (valid == (unsat_cnt == '0)));

    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(valid) && $stable(unsat_cnt)));

    a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && trk_on) |=> trk_cnt != '0);
endmodule

bind qc_syndrome_check qc_syndrome_check_sva #(.MB(MB), .CNT_W(CNT_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .valid     (valid),
    .unsat_cnt (unsat_cnt)
);

// File: tb/test_qc_syndrome_check.sv
module test_qc_syndrome_check;
    localparam int Z = 8, MB = 3, NB = 6, N = NB * Z;
    localparam int SAT_W = 3, SAT_MAX = 7;
    localparam int EMPTY = 63;
    localparam int TBL [MB][NB] = '{
        '{0,  3,  63, 5,  1,  63},
        '{63, 2,  7,  0,  63, 4 },
        '{6,  63, 1,  63, 0,  0 }};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N-1:0] cw_in = '0;
    logic done_a, valid_a, done_b, valid_b;
    logic [4:0] cnt_a;
    logic [SAT_W-1:0] cnt_b;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    qc_syndrome_check i_qc_syndrome_check (
        .clk(clk), .rst_n(rst_n), .start(start), .cw_in(cw_in),
        .done(done_a), .valid(valid_a), .unsat_cnt(cnt_a));

    qc_syndrome_check #(.CNT_W(SAT_W)) i_qc_syndrome_check_sat (
        .clk(clk), .rst_n(rst_n), .start(start), .cw_in(cw_in),
        .done(done_b), .valid(valid_b), .unsat_cnt(cnt_b));

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // R2 R3: count of failing checks computed from the shift table
    function automatic int ref_count(input logic [N-1:0] w);
        int n = 0;
        for (int i = 0; i < MB; i++) begin
            for (int r = 0; r < Z; r++) begin
                logic b = 1'b0;
                for (int j = 0; j < NB; j++) begin
                    if (TBL[i][j] != EMPTY) b ^= w[j*Z + ((r + TBL[i][j]) % Z)];
                end
                if (b) n++;
            end
        end
        return n;
    endfunction

    task automatic run_word(input logic [N-1:0] w, input bit poke,
                            input logic [N-1:0] other);
        int lat = 0;
        int pop = ref_count(w);
        int prev_v = int'(valid_a);
        int prev_c = int'(cnt_a);
        @(negedge clk);
        chk("R8 valid held", int'(valid_a), prev_v);
        chk("R8 count held", int'(cnt_a), prev_c);
        cw_in = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cw_in = ~w;                        // R9 disturbance after capture
        for (int k = 1; k <= 12; k++) begin
            if (done_a) begin lat = k; break; end
            if (poke && k == 2) begin      // R7 start while scanning
                start = 1'b1;
                cw_in = other;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R5 latency", lat, MB + 2);
        chk("R4 R9 valid", int'(valid_a), int'(pop == 0));
        chk("R2 R4 unsat_cnt", int'(cnt_a), pop);
        chk("R6 saturated count", int'(cnt_b), (pop > SAT_MAX) ? SAT_MAX : pop);
        @(negedge clk);
        chk("R5 done single pulse", int'(done_a), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R5 watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 done in reset", int'(done_a), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 done", int'(done_a), 0);
        chk("R1 valid", int'(valid_a), 0);
        chk("R1 unsat_cnt", int'(cnt_a), 0);

        run_word('0, 1'b0, '0);
        run_word('1, 1'b0, '0);            // R3 every row has four live blocks
        for (int a = 0; a < N; a++) begin  // R2 R3 single-bit sweep
            logic [N-1:0] w = '0;
            w[a] = 1'b1;
            run_word(w, 1'b0, '0);
        end
        for (int a = 0; a < N; a++) begin  // pairs
            for (int b = a + 1; b < N; b++) begin
                logic [N-1:0] w = '0;
                w[a] = 1'b1;
                w[b] = 1'b1;
                run_word(w, 1'b0, '0);
            end
        end
        for (int t = 0; t < 200; t++) begin // R6 R7 random words, busy pokes
            logic [63:0] tmp = {$urandom(), $urandom()};
            run_word(tmp[N-1:0], t[0], (t[1]) ? '0 : ~tmp[N-1:0]);
        end
        run_word('1, 1'b1, 48'h1);         // R7 valid word survives an invalid poke
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule